// File: doc/BRIEF.md
# Paging Control Register Update Unit

This unit holds the three paging and protection control registers of a 32-bit processor core, CR0, CR3 and CR4, and the address-line-20 gate. A single write port carries a selector, a data word and an enable. An A20 port carries a gate state and an enable. Each write is compared with the value already held. When the bits that govern address translation change, the unit raises a translation-cache invalidate strobe. The strobe is either global or limited to non-global entries.

Every accepted write also recomputes the hidden mode flags that the pipeline needs. These are the protected-mode flag, the segment-base-add flag, the three floating-point trap flags and the extended-state save enable. The unit also tracks the long-mode-active state, using a long-mode-enable input and the current physical-address-extension setting. A feature input says whether the vector extension is supported, and a write to CR4 cannot enable extended state without it.

Top module: `ctl_reg_unit`

## Requirements
- R1: While rst_ni is low, and after it rises, CR0 reads 0x60000010. CR3 and CR4 read 0 and the A20 mask reads 0xFFFFFFFF. pe_o, mp_o, em_o, ts_o, osfxsr_o and lma_o are 0, addseg_o is 1 and both flush strobes are 0.
- R2: A write with wr_sel_i = 0 stores the data into CR0 with bit 4 forced to 1. In the same clock edge pe_o takes bit 0, mp_o bit 1, em_o bit 2 and ts_o bit 3, and addseg_o becomes the inverse of bit 0.
- R3: A CR0 write that changes bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable) pulses flush_all_o. Changes limited to other bits do not pulse it.
- R4: A CR0 write that sets bit 31 while bit 31 is clear, with lme_i = 1 and CR4 bit 5 clear, leaves CR0 and every derived flag unchanged. R3 still applies to it. With CR4 bit 5 set, the same write stores CR0 and sets lma_o. A CR0 write that clears bit 31 while it is set clears lma_o. A write that sets bit 31 with lme_i = 0 leaves lma_o at 0.
- R5: A write with wr_sel_i = 1 stores CR3. It pulses flush_local_o only if CR0 bit 31 is set, and it never pulses flush_all_o.
- R6: A write with wr_sel_i = 2 pulses flush_all_o when CR4 bit 7, bit 5 or bit 4 changes. A rewrite of the same value pulses nothing.
- R7: A CR4 write stores bit 9 as 0 when sse_avail_i is 0. osfxsr_o always equals the stored bit 9.
- R8: An A20 write whose state differs from the current one pulses flush_all_o. The mask then becomes 0xFFEFFFFF with bit 20 equal to the new state. A write of the current state changes nothing.
- R9: Each flush strobe is registered. It is high for exactly the one cycle that follows the edge that takes the triggering write, and it falls when no trigger arrives at the next edge. A CR write and an A20 write in the same cycle are both applied.
- R10: With wr_en_i low, or with wr_sel_i = 3, the write port changes no register, flag or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write enable |
| wr_sel_i | input | 2 | Target: 0 CR0, 1 CR3, 2 CR4, 3 none |
| wr_data_i | input | 32 | Write data |
| a20_wr_i | input | 1 | A20 gate write enable |
| a20_state_i | input | 1 | New A20 gate state |
| sse_avail_i | input | 1 | Vector extension supported |
| lme_i | input | 1 | Long mode enable |
| cr0_o | output | 32 | Current CR0 |
| cr3_o | output | 32 | Current CR3 |
| cr4_o | output | 32 | Current CR4 |
| a20_mask_o | output | 32 | Physical address mask |
| pe_o | output | 1 | Protected mode flag |
| addseg_o | output | 1 | Segment-base-add flag |
| mp_o | output | 1 | Monitor coprocessor flag |
| em_o | output | 1 | FPU emulation flag |
| ts_o | output | 1 | Task switched flag |
| osfxsr_o | output | 1 | Extended state save enabled |
| lma_o | output | 1 | Long mode active |
| flush_all_o | output | 1 | Global invalidate strobe |
| flush_local_o | output | 1 | Non-global invalidate strobe |

## Verification
The A20 gate and the control register port are independent, so a gate toggle can fall in the same cycle as a CR0 write that also changes a flush-relevant bit. The bench provokes this with one vector that raises a20_wr_i together with a CR0 write that sets write-protect while paging is on. It then checks that the new CR0, the restored mask and a single flush_all_o pulse all appear on the same following cycle. It also checks that lma_o is not disturbed by that write.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int XLEN = 32;

  localparam int CR0_PE = 0;
  localparam int CR0_MP = 1;
  localparam int CR0_EM = 2;
  localparam int CR0_TS = 3;
  localparam int CR0_ET = 4;
  localparam int CR0_WP = 16;
  localparam int CR0_PG = 31;

  localparam int CR4_PSE  = 4;
  localparam int CR4_PAE  = 5;
  localparam int CR4_PGE  = 7;
  localparam int CR4_OSFX = 9;

  localparam logic [XLEN-1:0] ONE_W = XLEN'(1);
  localparam logic [XLEN-1:0] CR0_RST = 32'h6000_0010;
  localparam logic [XLEN-1:0] CR0_FLUSH_MASK =
    (ONE_W << CR0_PG) | (ONE_W << CR0_WP) | (ONE_W << CR0_PE);
  localparam logic [XLEN-1:0] CR4_FLUSH_MASK =
    (ONE_W << CR4_PGE) | (ONE_W << CR4_PAE) | (ONE_W << CR4_PSE);

  typedef enum logic [1:0] {
    SEL_CR0  = 2'd0,
    SEL_CR3  = 2'd1,
    SEL_CR4  = 2'd2,
    SEL_NONE = 2'd3
  } cr_sel_e;

  typedef struct packed {
    logic pe;
    logic addseg;
    logic mp;
    logic em;
    logic ts;
    logic osfxsr;
  } mode_flags_t;
endpackage

// File: rtl/ctl_cr0_stage.sv
module ctl_cr0_stage
  import ctl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [XLEN-1:0] data_i,
  input  logic            lme_i,
  input  logic            pae_i,
  output logic [XLEN-1:0] cr0_o,
  output logic [XLEN-1:0] cr0_nxt_o,
  output logic            load_o,
  output logic            lma_o,
  output logic            flush_req_o
);
  logic [XLEN-1:0] cr0_q;
  logic            lma_q;
  logic            pg_on, pg_off, blocked;

  assign pg_on   = !cr0_q[CR0_PG] && data_i[CR0_PG];
  assign pg_off  = cr0_q[CR0_PG] && !data_i[CR0_PG];
  // long-mode entry without address extension is refused
  assign blocked = pg_on && lme_i && !pae_i;

  assign load_o      = wr_i && !blocked;
  assign cr0_nxt_o   = data_i | (ONE_W << CR0_ET);
  assign flush_req_o = wr_i && (((data_i ^ cr0_q) & CR0_FLUSH_MASK) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr0_q <= CR0_RST;
      lma_q <= 1'b0;
    end else if (load_o) begin
      cr0_q <= cr0_nxt_o;
      if (pg_on && lme_i)      lma_q <= 1'b1;
      else if (pg_off)         lma_q <= 1'b0;
    end
  end

  assign cr0_o = cr0_q;
  assign lma_o = lma_q;
endmodule

// File: rtl/ctl_cr4_stage.sv
module ctl_cr4_stage
  import ctl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [XLEN-1:0] data_i,
  input  logic            sse_avail_i,
  output logic [XLEN-1:0] cr4_o,
  output logic [XLEN-1:0] cr4_nxt_o,
  output logic            flush_req_o
);
  logic [XLEN-1:0] cr4_q;

  assign cr4_nxt_o   = sse_avail_i ? data_i : (data_i & ~(ONE_W << CR4_OSFX));
  assign flush_req_o = wr_i && (((data_i ^ cr4_q) & CR4_FLUSH_MASK) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cr4_q <= '0;
    else if (wr_i) cr4_q <= cr4_nxt_o;
  end

  assign cr4_o = cr4_q;
endmodule

// File: rtl/ctl_a20_gate.sv
module ctl_a20_gate #(
  parameter int ADDR_W  = 32,
  parameter int GATE_BIT = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              state_i,
  output logic [ADDR_W-1:0] mask_o,
  output logic              flush_req_o
);
  localparam logic [ADDR_W-1:0] GATE_ONE = ADDR_W'(1) << GATE_BIT;

  logic state_q;

  assign flush_req_o = wr_i && (state_i != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          state_q <= 1'b1;
    else if (flush_req_o) state_q <= state_i;
  end

  assign mask_o = ~GATE_ONE | (state_q ? GATE_ONE : '0);
endmodule

// File: rtl/ctl_mode_flags.sv
module ctl_mode_flags
  import ctl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cr0_load_i,
  input  logic [XLEN-1:0] cr0_d_i,
  input  logic            cr4_load_i,
  input  logic [XLEN-1:0] cr4_d_i,
  output mode_flags_t     flags_o
);
  localparam mode_flags_t FLAGS_RST = '{
    pe:     CR0_RST[CR0_PE],
    addseg: !CR0_RST[CR0_PE],
    mp:     CR0_RST[CR0_MP],
    em:     CR0_RST[CR0_EM],
    ts:     CR0_RST[CR0_TS],
    osfxsr: 1'b0
  };

  mode_flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= FLAGS_RST;
    end else begin
      if (cr0_load_i) begin
        flags_q.pe     <= cr0_d_i[CR0_PE];
        flags_q.addseg <= !cr0_d_i[CR0_PE];
        flags_q.mp     <= cr0_d_i[CR0_MP];
        flags_q.em     <= cr0_d_i[CR0_EM];
        flags_q.ts     <= cr0_d_i[CR0_TS];
      end
      if (cr4_load_i) flags_q.osfxsr <= cr4_d_i[CR4_OSFX];
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/ctl_reg_unit.sv
module ctl_reg_unit
  import ctl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GATE_BIT = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic              a20_wr_i,
  input  logic              a20_state_i,
  input  logic              sse_avail_i,
  input  logic              lme_i,
  output logic [XLEN-1:0]   cr0_o,
  output logic [XLEN-1:0]   cr3_o,
  output logic [XLEN-1:0]   cr4_o,
  output logic [ADDR_W-1:0] a20_mask_o,
  output logic              pe_o,
  output logic              addseg_o,
  output logic              mp_o,
  output logic              em_o,
  output logic              ts_o,
  output logic              osfxsr_o,
  output logic              lma_o,
  output logic              flush_all_o,
  output logic              flush_local_o
);
  cr_sel_e         sel;
  logic            wr_cr0, wr_cr3, wr_cr4;
  logic [XLEN-1:0] cr0_nxt, cr4_nxt, cr3_q;
  logic            cr0_load;
  logic            fr_cr0, fr_cr4, fr_a20;
  logic            flush_all_q, flush_local_q;
  mode_flags_t     flags;

  assign sel    = cr_sel_e'(wr_sel_i);
  assign wr_cr0 = wr_en_i && (sel == SEL_CR0);
  assign wr_cr3 = wr_en_i && (sel == SEL_CR3);
  assign wr_cr4 = wr_en_i && (sel == SEL_CR4);

  ctl_cr0_stage u_cr0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_cr0),
    .data_i      (wr_data_i),
    .lme_i       (lme_i),
    .pae_i       (cr4_o[CR4_PAE]),
    .cr0_o       (cr0_o),
    .cr0_nxt_o   (cr0_nxt),
    .load_o      (cr0_load),
    .lma_o       (lma_o),
    .flush_req_o (fr_cr0)
  );

  ctl_cr4_stage u_cr4 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_cr4),
    .data_i      (wr_data_i),
    .sse_avail_i (sse_avail_i),
    .cr4_o       (cr4_o),
    .cr4_nxt_o   (cr4_nxt),
    .flush_req_o (fr_cr4)
  );

  ctl_a20_gate #(
    .ADDR_W   (ADDR_W),
    .GATE_BIT (GATE_BIT)
  ) u_a20 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (a20_wr_i),
    .state_i     (a20_state_i),
    .mask_o      (a20_mask_o),
    .flush_req_o (fr_a20)
  );

  ctl_mode_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cr0_load_i (cr0_load),
    .cr0_d_i    (cr0_nxt),
    .cr4_load_i (wr_cr4),
    .cr4_d_i    (cr4_nxt),
    .flags_o    (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr3_q         <= '0;
      flush_all_q   <= 1'b0;
      flush_local_q <= 1'b0;
    end else begin
      if (wr_cr3) cr3_q <= wr_data_i;
      flush_all_q   <= fr_cr0 || fr_cr4 || fr_a20;
      flush_local_q <= wr_cr3 && cr0_o[CR0_PG];
    end
  end

  assign cr3_o         = cr3_q;
  assign flush_all_o   = flush_all_q;
  assign flush_local_o = flush_local_q;
  assign pe_o          = flags.pe;
  assign addseg_o      = flags.addseg;
  assign mp_o          = flags.mp;
  assign em_o          = flags.em;
  assign ts_o          = flags.ts;
  assign osfxsr_o      = flags.osfxsr;
endmodule

// File: rtl/ctl_reg_unit_chk.sv
module ctl_reg_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_sel_i,
  input logic        a20_wr_i,
  input logic [31:0] cr0_o,
  input logic [31:0] cr3_o,
  input logic [31:0] cr4_o,
  input logic [31:0] a20_mask_o,
  input logic        pe_o,
  input logic        addseg_o,
  input logic        mp_o,
  input logic        em_o,
  input logic        ts_o,
  input logic        osfxsr_o,
  input logic        lma_o,
  input logic        flush_all_o,
  input logic        flush_local_o
);
  assert_flag_mirror_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({ts_o, em_o, mp_o, pe_o} == cr0_o[3:0]) && (addseg_o == !pe_o) && cr0_o[4]);

  assert_lma_needs_pg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lma_o |-> cr0_o[31]);

  assert_local_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_local_o |-> $past(wr_en_i && (wr_sel_i == 2'd1) && cr0_o[31]));

  assert_osfx_mirror_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osfxsr_o == cr4_o[9]);

  assert_mask_shape_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &(a20_mask_o | 32'h0010_0000));

  assert_all_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_o |-> $past(wr_en_i || a20_wr_i));

  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) || ($past(wr_sel_i) == 2'd3)) |->
      ($stable(cr0_o) && $stable(cr3_o) && $stable(cr4_o) && !flush_local_o));
endmodule

bind ctl_reg_unit ctl_reg_unit_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_sel_i      (wr_sel_i),
  .a20_wr_i      (a20_wr_i),
  .cr0_o         (cr0_o),
  .cr3_o         (cr3_o),
  .cr4_o         (cr4_o),
  .a20_mask_o    (a20_mask_o),
  .pe_o          (pe_o),
  .addseg_o      (addseg_o),
  .mp_o          (mp_o),
  .em_o          (em_o),
  .ts_o          (ts_o),
  .osfxsr_o      (osfxsr_o),
  .lma_o         (lma_o),
  .flush_all_o   (flush_all_o),
  .flush_local_o (flush_local_o)
);

// File: tb/ctl_reg_unit_tb.sv
module ctl_reg_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int NVEC  = 18;

  typedef struct packed {
    logic        a20w;
    logic        a20s;
    logic        we;
    logic [1:0]  sel;
    logic [31:0] data;
    logic        lme;
    logic        sse;
    logic [31:0] e_cr0;
    logic [31:0] e_cr3;
    logic [31:0] e_cr4;
    logic [31:0] e_mask;
    logic [6:0]  e_flg; // {pe, addseg, mp, em, ts, osfxsr, lma}
    logic        e_fa;
    logic        e_fl;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    // R5: CR3 write with paging off, no local flush
    '{1'b0,1'b0,1'b1,2'd1,32'h0000_1000,1'b0,1'b0, 32'h0000_0011-32'h1+32'h6000_0000,32'h1000,32'h0,32'hFFFF_FFFF,7'b0100000,1'b0,1'b0,4'd5},
    // R2: trap bits copied, ET forced, no flush
    '{1'b0,1'b0,1'b1,2'd0,32'h0000_000E,1'b0,1'b0, 32'h0000_001E,32'h1000,32'h0,32'hFFFF_FFFF,7'b0111100,1'b0,1'b0,4'd2},
    // R3: PE change flushes, R2 flags follow
    '{1'b0,1'b0,1'b1,2'd0,32'h0000_0001,1'b0,1'b0, 32'h0000_0011,32'h1000,32'h0,32'hFFFF_FFFF,7'b1000000,1'b1,1'b0,4'd3},
    // R7: OSFXSR dropped without SSE
    '{1'b0,1'b0,1'b1,2'd2,32'h0000_0200,1'b0,1'b0, 32'h0000_0011,32'h1000,32'h0,32'hFFFF_FFFF,7'b1000000,1'b0,1'b0,4'd7},
    // R6/R7: PSE change flushes, OSFXSR kept with SSE
    '{1'b0,1'b0,1'b1,2'd2,32'h0000_0210,1'b0,1'b1, 32'h0000_0011,32'h1000,32'h210,32'hFFFF_FFFF,7'b1000010,1'b1,1'b0,4'd6},
    // R4: paging on with lme but no PAE is refused, flush still per R3
    '{1'b0,1'b0,1'b1,2'd0,32'h8000_0011,1'b1,1'b1, 32'h0000_0011,32'h1000,32'h210,32'hFFFF_FFFF,7'b1000010,1'b1,1'b0,4'd4},
    // R6: PAE change flushes
    '{1'b0,1'b0,1'b1,2'd2,32'h0000_0230,1'b1,1'b1, 32'h0000_0011,32'h1000,32'h230,32'hFFFF_FFFF,7'b1000010,1'b1,1'b0,4'd6},
    // R4: paging on with lme and PAE sets lma
    '{1'b0,1'b0,1'b1,2'd0,32'h8000_0001,1'b1,1'b1, 32'h8000_0011,32'h1000,32'h230,32'hFFFF_FFFF,7'b1000011,1'b1,1'b0,4'd4},
    // R5: CR3 write with paging on
    '{1'b0,1'b0,1'b1,2'd1,32'h0000_2000,1'b1,1'b1, 32'h8000_0011,32'h2000,32'h230,32'hFFFF_FFFF,7'b1000011,1'b0,1'b1,4'd5},
    // R8: gate closed
    '{1'b1,1'b0,1'b0,2'd0,32'h0,1'b1,1'b1, 32'h8000_0011,32'h2000,32'h230,32'hFFEF_FFFF,7'b1000011,1'b1,1'b0,4'd8},
    // R8: same state again, nothing
    '{1'b1,1'b0,1'b0,2'd0,32'h0,1'b1,1'b1, 32'h8000_0011,32'h2000,32'h230,32'hFFEF_FFFF,7'b1000011,1'b0,1'b0,4'd8},
    // R9: gate reopened together with a CR0 WP change
    '{1'b1,1'b1,1'b1,2'd0,32'h8001_0011,1'b1,1'b1, 32'h8001_0011,32'h2000,32'h230,32'hFFFF_FFFF,7'b1000011,1'b1,1'b0,4'd9},
    // R4: paging off clears lma
    '{1'b0,1'b0,1'b1,2'd0,32'h0000_0011,1'b0,1'b1, 32'h0000_0011,32'h2000,32'h230,32'hFFFF_FFFF,7'b1000010,1'b1,1'b0,4'd4},
    // R10: selector 3 does nothing; R9 strobe falls
    '{1'b0,1'b0,1'b1,2'd3,32'hFFFF_FFFF,1'b0,1'b1, 32'h0000_0011,32'h2000,32'h230,32'hFFFF_FFFF,7'b1000010,1'b0,1'b0,4'd10},
    // R4: paging on without lme leaves lma clear
    '{1'b0,1'b0,1'b1,2'd0,32'h8000_0011,1'b0,1'b1, 32'h8000_0011,32'h2000,32'h230,32'hFFFF_FFFF,7'b1000010,1'b1,1'b0,4'd4},
    // R5: local flush, no global
    '{1'b0,1'b0,1'b1,2'd1,32'h0000_3000,1'b0,1'b1, 32'h8000_0011,32'h3000,32'h230,32'hFFFF_FFFF,7'b1000010,1'b0,1'b1,4'd5},
    // R6: same CR4 value, no flush
    '{1'b0,1'b0,1'b1,2'd2,32'h0000_0230,1'b0,1'b1, 32'h8000_0011,32'h3000,32'h230,32'hFFFF_FFFF,7'b1000010,1'b0,1'b0,4'd6},
    // R10: enable low with CR0 data present
    '{1'b0,1'b0,1'b0,2'd0,32'h0000_0000,1'b0,1'b1, 32'h8000_0011,32'h3000,32'h230,32'hFFFF_FFFF,7'b1000010,1'b0,1'b0,4'd10}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd3;
  logic [31:0] wr_data_i = '0;
  logic        a20_wr_i = 1'b0;
  logic        a20_state_i = 1'b0;
  logic        sse_avail_i = 1'b0;
  logic        lme_i = 1'b0;
  logic [31:0] cr0_o, cr3_o, cr4_o, a20_mask_o;
  logic        pe_o, addseg_o, mp_o, em_o, ts_o, osfxsr_o, lma_o;
  logic        flush_all_o, flush_local_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  ctl_reg_unit dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .a20_wr_i, .a20_state_i, .sse_avail_i, .lme_i,
    .cr0_o, .cr3_o, .cr4_o, .a20_mask_o,
    .pe_o, .addseg_o, .mp_o, .em_o, .ts_o, .osfxsr_o, .lma_o,
    .flush_all_o, .flush_local_o
  );

  task automatic check(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input int req, input logic [31:0] e0, input logic [31:0] e3,
                           input logic [31:0] e4, input logic [31:0] em,
                           input logic [6:0] ef, input logic efa, input logic efl);
    check("cr0", req, cr0_o, e0);
    check("cr3", req, cr3_o, e3);
    check("cr4", req, cr4_o, e4);
    check("a20_mask", req, a20_mask_o, em);
    check("flags", req, 32'({pe_o, addseg_o, mp_o, em_o, ts_o, osfxsr_o, lma_o}), 32'(ef));
    check("flush_all", req, 32'(flush_all_o), 32'(efa));
    check("flush_local", req, 32'(flush_local_o), 32'(efl));
  endtask

  initial begin
    #(CLK_P * 4000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: values held during reset
    #(CLK_P * 2 + 1);
    check_all(1, 32'h6000_0010, 32'h0, 32'h0, 32'hFFFF_FFFF, 7'b0100000, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: values after release
    check_all(1, 32'h6000_0010, 32'h0, 32'h0, 32'hFFFF_FFFF, 7'b0100000, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      a20_wr_i    = VEC[i].a20w;
      a20_state_i = VEC[i].a20s;
      wr_en_i     = VEC[i].we;
      wr_sel_i    = VEC[i].sel;
      wr_data_i   = VEC[i].data;
      lme_i       = VEC[i].lme;
      sse_avail_i = VEC[i].sse;
      @(negedge clk_i);
      check_all(int'(VEC[i].req), VEC[i].e_cr0, VEC[i].e_cr3, VEC[i].e_cr4,
                VEC[i].e_mask, VEC[i].e_flg, VEC[i].e_fa, VEC[i].e_fl);
    end

    // R9: a lone trigger gives one pulse that falls when the port goes idle
    wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = 32'h8000_0010; lme_i = 1'b0;
    @(negedge clk_i);
    check("flush_all pulse", 9, 32'(flush_all_o), 32'h1);
    wr_en_i = 1'b0;
    @(negedge clk_i);
    check("flush_all fall", 9, 32'(flush_all_o), 32'h0);
    // R2: PE cleared again sets addseg, pe low
    check("addseg", 2, 32'({pe_o, addseg_o}), 32'h1);

    // R1: asynchronous reset mid-run
    a20_wr_i = 1'b1; a20_state_i = 1'b0;
    @(negedge clk_i);
    a20_wr_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1;
    check_all(1, 32'h6000_0010, 32'h0, 32'h0, 32'hFFFF_FFFF, 7'b0100000, 1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule